// File: doc/BRIEF.md
# Barrel Shifter with Carry and Extend Flags

This block shifts a 32-bit operand left logically, right logically or right arithmetically by a count that arrives from a register. Besides the shifted word it reports the carry, which is the last bit pushed out of the word, and an extend flag that copies the carry. A stage that follows derives the negative and zero flags from the result, so the block does not produce them.

The count is reduced modulo 64 before use, which gives every count a defined outcome: counts of 32 and above clear the word (logical kinds) or flood it with the sign bit (arithmetic kind), and a count of zero leaves the word alone and forwards the carry supplied by the caller. The datapath is combinational. A parameter chooses whether a reset register stage sits on the outputs, which is the default, or whether they follow the inputs directly.

Top module: `shf_flag_shifter`

## Requirements
- R1: Only the low six bits of the 8-bit count input matter; a raw count c and c+64 (or c+128, c+192) give identical outputs.
- R2: With a reduced count of zero the result equals the operand and both carry and extend equal the carry input.
- R3: A logical left shift by n in 1..31 gives the operand shifted left by n with zeros entering at bit 0, and carry equals operand bit 32-n.
- R4: A logical right shift by n in 1..31 gives the operand shifted right by n with zeros entering at bit 31, and carry equals operand bit n-1.
- R5: An arithmetic right shift by n in 1..31 fills the vacated upper bits with operand bit 31, and carry equals operand bit n-1.
- R6: A logical shift by exactly 32 gives a zero result; carry is operand bit 0 for a left shift and operand bit 31 for a right shift.
- R7: A logical shift by 33 to 63 gives a zero result and a clear carry.
- R8: An arithmetic right shift by 32 to 63 gives a result whose every bit equals operand bit 31, and carry equals operand bit 31.
- R9: The extend output always equals the carry output.
- R10: The kind input encodes 2'b00 as logical left, 2'b01 as logical right, 2'b10 as arithmetic right, and 2'b11 behaves exactly as logical left.
- R11: With the output stage present, outputs show the function of the inputs sampled at the previous rising clock edge, and an active-low reset clears result, carry and extend to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| src_val | input | 32 | Operand to be shifted |
| shamt | input | 8 | Raw shift count, used modulo 64 |
| kind | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 left |
| carry_in | input | 1 | Previous carry, forwarded on a zero count |
| result | output | 32 | Shifted word |
| carry_out | output | 1 | Last bit shifted out, or carry_in on a zero count |
| ext_out | output | 1 | Extend flag, a copy of the carry |

## Verification
The count wrap and the width boundaries meet in one cycle when a raw count above 63 folds onto 0, 32 or a value just past 32, so the bench drives raw counts 64, 96, 97 and 128 under every kind and with both carry inputs. Each such cycle is judged against a reference that shifts one bit at a time and keeps the bit that fell out, so the zero-count pass-through and the exact-32 carry selection are both tested through the wrap rather than only at small counts.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        SHK_LSL     = 2'b00,
        SHK_LSR     = 2'b01,
        SHK_ASR     = 2'b10,
        SHK_LSL_ALT = 2'b11
    } shift_kind_e;

    localparam int unsigned NUM_LANES = 3;
    localparam int unsigned LANE_LSL  = 0;
    localparam int unsigned LANE_LSR  = 1;
    localparam int unsigned LANE_ASR  = 2;

endpackage

// File: rtl/shf_count_reduce.sv
module shf_count_reduce #(
    parameter int unsigned CNT_IN_W = 8,
    parameter int unsigned CNT_W    = 6
) (
    input  logic [CNT_IN_W-1:0] raw_cnt,
    output logic [CNT_W-1:0]    amt,
    output logic                amt_zero
);

    // Modulo 2**CNT_W: the upper bits are discarded.
    assign amt      = raw_cnt[CNT_W-1:0];
    assign amt_zero = (amt == '0);

    generate
        if (CNT_IN_W > CNT_W) begin : g_drop_hi
            logic unused_hi_bits;
            assign unused_hi_bits = ^raw_cnt[CNT_IN_W-1:CNT_W];
        end
    endgenerate

endmodule

// File: rtl/shf_lane.sv
module shf_lane #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned CNT_W    = 6,
    parameter bit          DIR_LEFT = 1'b1,
    parameter bit          ARITH    = 1'b0
) (
    input  logic [DATA_W-1:0] src,
    input  logic [CNT_W-1:0]  amt,
    output logic [DATA_W-1:0] res,
    output logic              cout
);

    localparam int unsigned EXT_W = DATA_W + 1;

    generate
        if (DIR_LEFT) begin : g_left
            // One guard bit above the word catches the last bit leaving the top.
            logic [EXT_W-1:0] wide_l;
            assign wide_l = {1'b0, src} << amt;
            assign res    = wide_l[DATA_W-1:0];
            assign cout   = wide_l[DATA_W];
        end else if (ARITH) begin : g_arith
            // One guard bit below the word catches the last bit leaving the bottom.
            logic signed [EXT_W-1:0] wide_a;
            assign wide_a = $signed({src, 1'b0}) >>> amt;
            assign res    = wide_a[DATA_W:1];
            assign cout   = wide_a[0];
        end else begin : g_logic
            logic [EXT_W-1:0] wide_r;
            assign wide_r = {src, 1'b0} >> amt;
            assign res    = wide_r[DATA_W:1];
            assign cout   = wide_r[0];
        end
    endgenerate

endmodule

// File: rtl/shf_select.sv
module shf_select
    import shf_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  shift_kind_e       kind,
    input  logic              amt_zero,
    input  logic [DATA_W-1:0] src,
    input  logic              carry_in,
    input  logic [DATA_W-1:0] lane_res [NUM_LANES],
    input  logic              lane_cy  [NUM_LANES],
    output logic [DATA_W-1:0] sel_res,
    output logic              sel_cy
);

    always_comb begin
        sel_res = lane_res[LANE_LSL];
        sel_cy  = lane_cy[LANE_LSL];
        unique case (kind)
            SHK_LSL, SHK_LSL_ALT: begin
                sel_res = lane_res[LANE_LSL];
                sel_cy  = lane_cy[LANE_LSL];
            end
            SHK_LSR: begin
                sel_res = lane_res[LANE_LSR];
                sel_cy  = lane_cy[LANE_LSR];
            end
            SHK_ASR: begin
                sel_res = lane_res[LANE_ASR];
                sel_cy  = lane_cy[LANE_ASR];
            end
            default: begin
                sel_res = lane_res[LANE_LSL];
                sel_cy  = lane_cy[LANE_LSL];
            end
        endcase
        if (amt_zero) begin
            sel_res = src;
            sel_cy  = carry_in;
        end
    end

endmodule

// File: rtl/shf_flag_shifter.sv
module shf_flag_shifter
    import shf_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned CNT_IN_W = 8,
    parameter int unsigned CNT_W    = 6,
    parameter bit          REG_OUT  = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   src_val,
    input  logic [CNT_IN_W-1:0] shamt,
    input  logic [1:0]          kind,
    input  logic                carry_in,
    output logic [DATA_W-1:0]   result,
    output logic                carry_out,
    output logic                ext_out
);

    logic [CNT_W-1:0]  amt;
    logic              amt_zero;
    logic [DATA_W-1:0] lane_res [NUM_LANES];
    logic              lane_cy  [NUM_LANES];
    logic [DATA_W-1:0] nxt_res;
    logic              nxt_cy;
    shift_kind_e       kind_e;

    assign kind_e = shift_kind_e'(kind);

    shf_count_reduce #(
        .CNT_IN_W (CNT_IN_W),
        .CNT_W    (CNT_W)
    ) u_cnt (
        .raw_cnt  (shamt),
        .amt      (amt),
        .amt_zero (amt_zero)
    );

    generate
        for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
            shf_lane #(
                .DATA_W   (DATA_W),
                .CNT_W    (CNT_W),
                .DIR_LEFT (g == LANE_LSL),
                .ARITH    (g == LANE_ASR)
            ) u_lane (
                .src  (src_val),
                .amt  (amt),
                .res  (lane_res[g]),
                .cout (lane_cy[g])
            );
        end
    endgenerate

    shf_select #(
        .DATA_W (DATA_W)
    ) u_sel (
        .kind     (kind_e),
        .amt_zero (amt_zero),
        .src      (src_val),
        .carry_in (carry_in),
        .lane_res (lane_res),
        .lane_cy  (lane_cy),
        .sel_res  (nxt_res),
        .sel_cy   (nxt_cy)
    );

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    result    <= '0;
                    carry_out <= 1'b0;
                    ext_out   <= 1'b0;
                end else begin
                    result    <= nxt_res;
                    carry_out <= nxt_cy;
                    ext_out   <= nxt_cy;
                end
            end
        end else begin : g_comb
            assign result    = nxt_res;
            assign carry_out = nxt_cy;
            assign ext_out   = nxt_cy;
        end
    endgenerate

endmodule

// File: rtl/shf_flag_shifter_chk.sv
module shf_flag_shifter_chk
    import shf_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned CNT_IN_W = 8,
    parameter int unsigned CNT_W    = 6,
    parameter bit          REG_OUT  = 1'b1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [DATA_W-1:0]   src_val,
    input logic [CNT_IN_W-1:0] shamt,
    input logic [1:0]          kind,
    input logic                carry_in,
    input logic [DATA_W-1:0]   result,
    input logic                carry_out,
    input logic                ext_out
);

    logic [DATA_W-1:0]   v_q;
    logic [CNT_IN_W-1:0] s_q;
    logic [1:0]          k_q;
    logic                ci_q;
    logic                armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q   <= '0;
            s_q   <= '0;
            k_q   <= '0;
            ci_q  <= 1'b0;
            armed <= 1'b0;
        end else begin
            v_q   <= src_val;
            s_q   <= shamt;
            k_q   <= kind;
            ci_q  <= carry_in;
            armed <= 1'b1;
        end
    end

    // Operands that produced the outputs seen at this edge.
    logic [DATA_W-1:0] v_o;
    logic [CNT_W-1:0]  c_o;
    logic [1:0]        k_o;
    logic              ci_o;

    assign v_o  = REG_OUT ? v_q : src_val;
    assign c_o  = REG_OUT ? s_q[CNT_W-1:0] : shamt[CNT_W-1:0];
    assign k_o  = REG_OUT ? k_q : kind;
    assign ci_o = REG_OUT ? ci_q : carry_in;

    // R9
    a_r9_ext_tracks_carry: assert property (@(posedge clk) disable iff (!rst_n)
        ext_out == carry_out);

    // R2
    a_r2_zero_count_passes: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (c_o == '0) |-> (result == v_o && carry_out == ci_o));

    // R7
    a_r7_far_logical_clears: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (k_o != SHK_ASR && c_o > CNT_W'(DATA_W)) |-> (result == '0 && !carry_out));

    // R8
    a_r8_far_arith_floods: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (k_o == SHK_ASR && c_o >= CNT_W'(DATA_W))
            |-> (result == {DATA_W{v_o[DATA_W-1]}} && carry_out == v_o[DATA_W-1]));

    // R6
    a_r6_exact_width_right: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (k_o == SHK_LSR && c_o == CNT_W'(DATA_W)) |-> (result == '0 && carry_out == v_o[DATA_W-1]));

    // R11
    a_r11_reset_clears: assert property (@(posedge clk)
        (!rst_n && REG_OUT) |-> (result == '0 && !carry_out && !ext_out));

endmodule

bind shf_flag_shifter shf_flag_shifter_chk #(
    .DATA_W   (DATA_W),
    .CNT_IN_W (CNT_IN_W),
    .CNT_W    (CNT_W),
    .REG_OUT  (REG_OUT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_val   (src_val),
    .shamt     (shamt),
    .kind      (kind),
    .carry_in  (carry_in),
    .result    (result),
    .carry_out (carry_out),
    .ext_out   (ext_out)
);

// File: tb/tb_shf_flag_shifter.sv
module tb_shf_flag_shifter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_val = '0;
    logic [7:0]  shamt = '0;
    logic [1:0]  kind = '0;
    logic        carry_in = 1'b0;
    logic [31:0] result;
    logic        carry_out;
    logic        ext_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        cy;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    shf_flag_shifter dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_val   (src_val),
        .shamt     (shamt),
        .kind      (kind),
        .carry_in  (carry_in),
        .result    (result),
        .carry_out (carry_out),
        .ext_out   (ext_out)
    );

    // Bit-serial reference: move one place per step, remember what fell out.
    task automatic model(input logic [31:0] v, input logic [7:0] cnt, input logic [1:0] k,
                         input logic cin, output logic [31:0] r, output logic c);
        int steps;
        steps = int'(cnt) % 64;
        r = v;
        c = cin;
        for (int i = 0; i < steps; i++) begin
            if (k == 2'b01) begin
                c = r[0];
                r = {1'b0, r[31:1]};
            end else if (k == 2'b10) begin
                c = r[0];
                r = {r[31], r[31:1]};
            end else begin
                c = r[31];
                r = {r[30:0], 1'b0};
            end
        end
    endtask

    function automatic string class_tag(input logic [7:0] cnt, input logic [1:0] k);
        int n;
        n = int'(cnt) % 64;
        if (n == 0) return "R2";
        if (k == 2'b11) return "R10";
        if (k == 2'b10) return (n >= 32) ? "R8" : "R5";
        if (n == 32) return "R6";
        if (n > 32) return "R7";
        return (k == 2'b00) ? "R3" : "R4";
    endfunction

    task automatic check_due();
        exp_t e;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        n_checks++;
        if (result !== e.res || carry_out !== e.cy) begin
            n_fails++;
            $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                     e.tag, result, carry_out, e.res, e.cy);
        end
        n_checks++;
        if (ext_out !== e.cy) begin
            n_fails++;
            $display("FAIL R9 (%s): ext=%b expected %b", e.tag, ext_out, e.cy);
        end
    endtask

    // Sample the outputs due from the previous vector, then drive the next one.
    task automatic apply(input logic [31:0] v, input logic [7:0] cnt, input logic [1:0] k,
                         input logic cin, input string tag);
        exp_t e;
        @(negedge clk);
        check_due();
        src_val  = v;
        shamt    = cnt;
        kind     = k;
        carry_in = cin;
        model(v, cnt, k, cin, e.res, e.cy);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic finish_run();
        if (finished) return;
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        // R11: reset state, even with live inputs
        src_val  = 32'hFFFF_FFFF;
        shamt    = 8'd3;
        carry_in = 1'b1;
        repeat (3) @(negedge clk);
        n_checks++;
        if (result !== '0 || carry_out !== 1'b0 || ext_out !== 1'b0) begin
            n_fails++;
            $display("FAIL R11: result=%h carry=%b ext=%b expected 0 0 0",
                     result, carry_out, ext_out);
        end
        rst_n = 1'b1;

        // R2: zero count keeps operand, forwards carry both ways
        apply(32'hDEAD_BEEF, 8'd0, 2'b00, 1'b1, "R2");
        apply(32'hDEAD_BEEF, 8'd0, 2'b01, 1'b0, "R2");
        apply(32'h8000_0001, 8'd0, 2'b10, 1'b1, "R2");
        // R3 / R4 / R5 small and edge counts
        apply(32'h8000_0001, 8'd1, 2'b00, 1'b0, "R3");
        apply(32'h4000_0000, 8'd31, 2'b00, 1'b0, "R3");
        apply(32'h0000_0003, 8'd31, 2'b00, 1'b1, "R3");
        apply(32'h8000_0001, 8'd1, 2'b01, 1'b0, "R4");
        apply(32'h8000_0000, 8'd31, 2'b01, 1'b0, "R4");
        apply(32'h8000_0000, 8'd4, 2'b10, 1'b0, "R5");
        apply(32'h7000_0008, 8'd4, 2'b10, 1'b0, "R5");
        apply(32'hC000_0000, 8'd31, 2'b10, 1'b0, "R5");
        // R6: exactly 32
        apply(32'h0000_0001, 8'd32, 2'b00, 1'b0, "R6");
        apply(32'hFFFF_FFFE, 8'd32, 2'b00, 1'b1, "R6");
        apply(32'h8000_0000, 8'd32, 2'b01, 1'b0, "R6");
        apply(32'h7FFF_FFFF, 8'd32, 2'b01, 1'b1, "R6");
        // R7: beyond 32
        apply(32'hFFFF_FFFF, 8'd33, 2'b00, 1'b1, "R7");
        apply(32'hFFFF_FFFF, 8'd63, 2'b01, 1'b1, "R7");
        // R8: arithmetic floods
        apply(32'h8000_0000, 8'd32, 2'b10, 1'b0, "R8");
        apply(32'h7FFF_FFFF, 8'd40, 2'b10, 1'b1, "R8");
        apply(32'hFFFF_0000, 8'd63, 2'b10, 1'b0, "R8");
        // R10: code 11 acts as left
        apply(32'h8000_0001, 8'd1, 2'b11, 1'b0, "R10");
        apply(32'h0000_0001, 8'd32, 2'b11, 1'b0, "R10");
        // R1: wrap of the raw count meets the boundaries
        for (int k = 0; k < 4; k++) begin
            apply(32'h9234_5671, 8'd64,  2'(k), 1'b1, "R1");
            apply(32'h9234_5671, 8'd96,  2'(k), 1'b0, "R1");
            apply(32'h9234_5671, 8'd97,  2'(k), 1'b1, "R1");
            apply(32'h9234_5671, 8'd128, 2'(k), 1'b0, "R1");
            apply(32'h9234_5671, 8'd197, 2'(k), 1'b0, "R1");
        end
        // Mixed patterns over all kinds and counts
        for (int i = 0; i < 400; i++) begin
            logic [31:0] v;
            logic [7:0]  c;
            logic [1:0]  k;
            v = $urandom();
            c = 8'($urandom_range(0, 255));
            k = 2'($urandom_range(0, 3));
            apply(v, c, k, 1'($urandom_range(0, 1)), class_tag(c, k));
        end
        @(negedge clk);
        check_due();
        finish_run();
    end

endmodule